// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one global history register that records the outcomes of recent branches. To form a table index, the block XORs that history with a slice of the branch address. The index selects one entry in a single shared table of two-bit saturating counters, and the counter's upper bit gives the guess. Each cycle the front end may present one branch address and receives a taken/not-taken answer.

The history is updated speculatively. As soon as a prediction is made, its guessed direction is shifted into the history, so the branch that follows sees it. The predictor also hands back the table index it used and the history value it had before that update. The back end returns both values when the branch resolves.

At resolution the counter at the returned index is trained toward the real outcome. If the branch was mispredicted, the history is rebuilt from the returned checkpoint plus the real outcome, which discards every speculative bit added after that branch. Training always happens when a branch resolves, but the history is repaired only on a misprediction.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every table counter holds 1 (weakly not-taken) and the history register is zero. The first prediction is therefore not-taken and reports a history of zero.
- R2: The table index equals `pred_pc[PC_LSB +: HIST_W]` XOR the current history. It is output on `pred_index` in the same cycle.
- R3: `pred_taken` is 1 when the indexed counter is 2 or 3, and 0 when it is 0 or 1.
- R4: On a cycle with `pred_valid` high and no misprediction repair, the history shifts left by one at the clock edge. The new least significant bit is the `pred_taken` value of that cycle. `pred_ghist` shows the history from before the shift.
- R5: A resolve adds one to the counter at `res_index` when `res_taken` is 1 and subtracts one when `res_taken` is 0. The counter saturates at 3 and at 0.
- R6: A counter at 3 needs two not-taken resolves before its prediction turns to not-taken. After the first one it still predicts taken.
- R7: A resolve with `res_mispredict` high loads the history with `((res_ghist << 1) | res_taken)`, truncated to HIST_W bits, at the clock edge.
- R8: When a mispredict repair and a prediction fall in the same cycle, the repair decides the next history and that prediction's speculative bit is dropped. The prediction itself is still formed from the history held before the edge.
- R9: When a prediction reads the entry that a resolve trains in the same cycle, it sees the counter value from before training. The trained value is visible from the next cycle on.
- R10: A resolve with `res_mispredict` low leaves the history unchanged.
- R11: With `pred_valid` low and no repair, the history holds its value, however `pred_pc` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | A conditional branch is being predicted this cycle |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_index | output | HIST_W | Table index used; to be returned at resolve |
| pred_ghist | output | HIST_W | History before this prediction's update; checkpoint |
| res_valid | input | 1 | A branch resolves this cycle |
| res_index | input | HIST_W | Table index that the branch was predicted with |
| res_ghist | input | HIST_W | Checkpoint that the branch was predicted with |
| res_taken | input | 1 | Real outcome of the branch |
| res_mispredict | input | 1 | The earlier prediction was wrong |

## Verification
Prediction and resolution can occur in the same cycle. This produces two separate collisions. In the first, a correctly predicted resolve trains the entry that the prediction is reading. The bench checks that the prediction returns the old counter, that the trained value appears in the next cycle, and that the speculative history shift still takes place. In the second, a mispredict resolve lands in the same cycle as a new prediction. The bench checks that the next history equals the repaired checkpoint and not the shifted one, while the colliding prediction still reports the old history as its checkpoint.

// File: rtl/gshare_pkg.sv
`timescale 1ns/1ps
package gshare_pkg;

    // Two-bit saturating direction counter
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } dir_ctr_t;

    // Counter value after one resolved outcome, clamped at both ends
    function automatic dir_ctr_t ctr_train(dir_ctr_t cur, logic taken);
        dir_ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T)
                nxt = dir_ctr_t'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT)
                nxt = dir_ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // Direction implied by a counter: its upper bit
    function automatic logic ctr_says_taken(dir_ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/gshare_hash.sv
`timescale 1ns/1ps
module gshare_hash #(
    parameter int HIST_W = 10
) (
    input  logic [HIST_W-1:0] pc_slice,
    input  logic [HIST_W-1:0] hist,
    output logic [HIST_W-1:0] idx
);
    // Fold global history onto the address bits
    always_comb begin
        for (int b = 0; b < HIST_W; b++) begin
            idx[b] = pc_slice[b] ^ hist[b];
        end
    end
endmodule

// File: rtl/gshare_ghist.sv
`timescale 1ns/1ps
module gshare_ghist #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_ckpt,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist_q
);
    logic [HIST_W-1:0] hist_d;

    // Repair outranks the speculative shift
    always_comb begin
        hist_d = hist_q;
        if (fix_en)
            hist_d = {fix_ckpt[HIST_W-2:0], fix_bit};
        else if (spec_en)
            hist_d = {hist_q[HIST_W-2:0], spec_bit};
    end

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else
            hist_q <= hist_d;
    end

    // R4: speculative shift of the guessed direction
    assert_spec_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (spec_en && !fix_en) |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(spec_bit)});

    // R7: repair rebuilds history from checkpoint and outcome
    assert_repair_load_R7: assert property (@(posedge clk) disable iff (rst)
        (fix_en && !spec_en) |=> hist_q == {$past(fix_ckpt[HIST_W-2:0]), $past(fix_bit)});

    // R8: repair wins over a same-cycle speculative shift
    assert_repair_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (fix_en && spec_en) |=> hist_q == {$past(fix_ckpt[HIST_W-2:0]), $past(fix_bit)});

    // R11 / R10: idle history holds
    assert_hist_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!fix_en && !spec_en) |=> $stable(hist_q));
endmodule

// File: rtl/gshare_pht.sv
`timescale 1ns/1ps
module gshare_pht
    import gshare_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output dir_ctr_t         rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    dir_ctr_t tbl [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++)
                tbl[e] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_train(tbl[wr_idx], wr_taken);
        end
    end

    // Read returns the pre-training value in a colliding cycle
    assign rd_ctr = tbl[rd_idx];

    // R5: ceiling saturation
    assert_ctr_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl[wr_idx] == CTR_STRONG_T) |=> tbl[$past(wr_idx)] == CTR_STRONG_T);

    // R5: floor saturation
    assert_ctr_floor_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wr_idx] == CTR_STRONG_NT) |=> tbl[$past(wr_idx)] == CTR_STRONG_NT);

    // R6: one opposite outcome from strong-taken still predicts taken
    assert_hysteresis_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wr_idx] == CTR_STRONG_T) |=> tbl[$past(wr_idx)] == CTR_WEAK_T);
endmodule

// File: rtl/gshare_predictor.sv
`timescale 1ns/1ps
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 10,
    parameter int PC_LSB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pred_valid,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_index,
    output logic [HIST_W-1:0] pred_ghist,
    input  logic              res_valid,
    input  logic [HIST_W-1:0] res_index,
    input  logic [HIST_W-1:0] res_ghist,
    input  logic              res_taken,
    input  logic              res_mispredict
);
    localparam int IDX_W = HIST_W;

    logic [HIST_W-1:0] hist_now;
    logic [IDX_W-1:0]  idx_now;
    dir_ctr_t          ctr_now;
    logic              repair_en;
    logic              pc_unused;

    assign pc_unused = ^pred_pc;
    assign repair_en = res_valid && res_mispredict;

    gshare_hash #(.HIST_W(HIST_W)) u_hash (
        .pc_slice (pred_pc[PC_LSB +: HIST_W]),
        .hist     (hist_now),
        .idx      (idx_now)
    );

    gshare_pht #(.IDX_W(IDX_W)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx_now),
        .rd_ctr   (ctr_now),
        .wr_en    (res_valid),
        .wr_idx   (res_index),
        .wr_taken (res_taken)
    );

    gshare_ghist #(.HIST_W(HIST_W)) u_ghist (
        .clk      (clk),
        .rst      (rst),
        .spec_en  (pred_valid),
        .spec_bit (pred_taken),
        .fix_en   (repair_en),
        .fix_ckpt (res_ghist),
        .fix_bit  (res_taken),
        .hist_q   (hist_now)
    );

    assign pred_taken = ctr_says_taken(ctr_now);
    assign pred_index = idx_now;
    assign pred_ghist = hist_now;

    // R10: correct-path resolve alone does not disturb history
    assert_resolve_keeps_hist_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_mispredict && !pred_valid) |=> pred_ghist == $past(pred_ghist));
endmodule

// File: tb/gshare_predictor_test.sv
`timescale 1ns/1ps
module gshare_predictor_test;
    localparam int PC_W = 32;
    localparam int HW   = 10;
    localparam int MASK = (1 << HW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          pred_valid;
    logic [PC_W-1:0] pred_pc;
    logic          pred_taken;
    logic [HW-1:0] pred_index;
    logic [HW-1:0] pred_ghist;
    logic          res_valid;
    logic [HW-1:0] res_index;
    logic [HW-1:0] res_ghist;
    logic          res_taken;
    logic          res_mispredict;

    int n_run = 0;
    int n_bad = 0;
    int exp_hist = 0;

    always #4 clk = ~clk;

    gshare_predictor #(.PC_W(PC_W), .HIST_W(HW), .PC_LSB(2)) uut (
        .clk(clk), .rst(rst),
        .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_index(pred_index), .pred_ghist(pred_ghist),
        .res_valid(res_valid), .res_index(res_index), .res_ghist(res_ghist),
        .res_taken(res_taken), .res_mispredict(res_mispredict)
    );

    task automatic chk(string req, string what, int act, int expv);
        n_run++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [PC_W-1:0] pc_for(int idx, int hist);
        return PC_W'(((idx ^ hist) & MASK) << 2);
    endfunction

    // Look without updating
    task automatic peek(input logic [PC_W-1:0] pc, output int t, output int ix, output int gh);
        @(negedge clk);
        pred_valid = 1'b0; res_valid = 1'b0; pred_pc = pc;
        #1;
        t = int'(pred_taken); ix = int'(pred_index); gh = int'(pred_ghist);
    endtask

    task automatic predict(input logic [PC_W-1:0] pc, output int t, output int ix, output int gh);
        @(negedge clk);
        pred_valid = 1'b1; res_valid = 1'b0; pred_pc = pc;
        #1;
        t = int'(pred_taken); ix = int'(pred_index); gh = int'(pred_ghist);
        @(posedge clk); #1;
        pred_valid = 1'b0;
    endtask

    task automatic resolve(int ix, int gh, logic tk, logic mis);
        @(negedge clk);
        pred_valid = 1'b0; res_valid = 1'b1;
        res_index = HW'(ix); res_ghist = HW'(gh); res_taken = tk; res_mispredict = mis;
        @(posedge clk); #1;
        res_valid = 1'b0;
    endtask

    task automatic both(input logic [PC_W-1:0] pc, int ix, int gh, logic tk, logic mis,
                        output int t, output int pix, output int pgh);
        @(negedge clk);
        pred_valid = 1'b1; pred_pc = pc; res_valid = 1'b1;
        res_index = HW'(ix); res_ghist = HW'(gh); res_taken = tk; res_mispredict = mis;
        #1;
        t = int'(pred_taken); pix = int'(pred_index); pgh = int'(pred_ghist);
        @(posedge clk); #1;
        pred_valid = 1'b0; res_valid = 1'b0;
    endtask

    task automatic t_reset;
        int t, ix, gh;
        peek(32'h0, t, ix, gh);
        chk("R1", "taken after reset", t, 0);
        chk("R1", "history after reset", gh, 0);
        peek(32'h0000_1234, t, ix, gh);
        chk("R2", "index with zero history", ix, 'h08D);
        chk("R1", "untouched entry not-taken", t, 0);
    endtask

    task automatic t_spec;
        int t, ix, gh;
        resolve('h08D, 0, 1'b1, 1'b0);
        peek(32'h0000_1234, t, ix, gh);
        chk("R3", "counter 2 predicts taken", t, 1);
        chk("R10", "correct resolve keeps history", gh, 0);
        predict(32'h0000_1234, t, ix, gh);
        chk("R4", "checkpoint is pre-update history", gh, 0);
        exp_hist = 1;
        predict(32'h0000_1234, t, ix, gh);
        chk("R4", "history gained taken bit", gh, exp_hist);
        chk("R2", "index uses new history", ix, 'h08C);
        chk("R3", "counter 1 predicts not-taken", t, 0);
        exp_hist = 2;
    endtask

    task automatic t_hold;
        int t, ix, gh;
        for (int k = 0; k < 4; k++) peek(PC_W'(k * 'h44), t, ix, gh);
        chk("R11", "history held while idle", gh, exp_hist);
    endtask

    task automatic t_repair;
        int t, ix, gh;
        resolve('h08C, 1, 1'b1, 1'b1);
        exp_hist = 3;
        peek(pc_for('h08C, exp_hist), t, ix, gh);
        chk("R7", "history rebuilt from checkpoint", gh, exp_hist);
        chk("R5", "mispredicted entry trained up", t, 1);
    endtask

    task automatic t_saturate;
        int t, ix, gh;
        for (int k = 0; k < 3; k++) resolve('h100, exp_hist, 1'b1, 1'b0);
        resolve('h100, exp_hist, 1'b0, 1'b0);
        peek(pc_for('h100, exp_hist), t, ix, gh);
        chk("R6", "one not-taken from strong still taken", t, 1);
        resolve('h100, exp_hist, 1'b0, 1'b0);
        peek(pc_for('h100, exp_hist), t, ix, gh);
        chk("R6", "second not-taken flips", t, 0);
        for (int k = 0; k < 3; k++) resolve('h100, exp_hist, 1'b0, 1'b0);
        resolve('h100, exp_hist, 1'b1, 1'b0);
        peek(pc_for('h100, exp_hist), t, ix, gh);
        chk("R5", "floor clamp: one taken stays not-taken", t, 0);
        resolve('h100, exp_hist, 1'b1, 1'b0);
        peek(pc_for('h100, exp_hist), t, ix, gh);
        chk("R5", "second taken reaches weak taken", t, 1);
        chk("R10", "history after many resolves", gh, exp_hist);
    endtask

    task automatic t_read_collision;
        int t, ix, gh;
        both(pc_for('h200, exp_hist), 'h200, 0, 1'b1, 1'b0, t, ix, gh);
        chk("R9", "colliding read sees old counter", t, 0);
        chk("R2", "colliding index", ix, 'h200);
        exp_hist = ((exp_hist << 1) | 0) & MASK;
        peek(pc_for('h200, exp_hist), t, ix, gh);
        chk("R9", "trained value visible next cycle", t, 1);
        chk("R4", "shift still applied beside resolve", gh, exp_hist);
    endtask

    task automatic t_repair_collision;
        int t, ix, gh;
        both(32'h0, 'h3F0, 'h155, 1'b0, 1'b1, t, ix, gh);
        chk("R8", "colliding prediction reports old history", gh, exp_hist);
        exp_hist = (('h155 << 1) | 0) & MASK;
        peek(32'h0, t, ix, gh);
        chk("R8", "repair wins over shift", gh, exp_hist);
    endtask

    initial begin
        repeat (25000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; pred_valid = 1'b0; pred_pc = '0; res_valid = 1'b0;
        res_index = '0; res_ghist = '0; res_taken = 1'b0; res_mispredict = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_spec();
        t_hold();
        t_repair();
        t_saturate();
        t_read_collision();
        t_repair_collision();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule